// File: doc/BRIEF.md
# Crossbar Slave Port Arbiter with Halt

This block decides which of several bus masters owns one slave port of a crossbar. The slave-side address, control, write data and transfer type are taken from the owner. Ownership may change only at an arbitration point. That is a cycle in which the transfer-boundary strobe is high and the current owner is neither in a locked sequence nor part-way through a fixed-length burst. Among the masters that are requesting at that point, the lowest index wins. When no master requests, the port parks on the last owner and presents an idle transfer.

A halt request acts as an extra pseudo-master. A priority-select input sets its rank. With the bit at 0, the halt outranks every master and takes the port at the next arbitration point. With the bit at 1, it takes the port only at an arbitration point where no master is requesting. Once the halt has won, the port stays halted for as long as the request is held. While halted, no grant is given and every slave-side output is zero. When the request drops, the port resumes normal arbitration on the next cycle. A halt request that drops before it has won is simply forgotten.

The controller has two states. `ST_OWN` means a master owns the port, or the port is parked on one. `ST_HALT` means no master owns the port. The transitions are:
- OWN→OWN (rearbitrate), at an arbitration point.
- OWN→HALT (enter halt), at an arbitration point with the halt eligible.
- HALT→HALT (hold halt), while the request stays high.
- HALT→OWN (release), in the first cycle the request is low.

Reset puts the controller in `ST_OWN` parked on master 0, so no software set-up is needed.

Top module: `slvport_arbiter`

## Requirements
- R1: After reset the port is parked on master 0, with grant = 0001, halted = 0 and slave transfer type = 2'b00 (IDLE).
- R2: At an arbitration point with no eligible halt, the requesting master with the lowest index becomes owner from the next cycle. The grant is one-hot whenever the port is not halted.
- R3: Without an arbitration point (xfer_end low, or the owner's hold bit high), the grant is unchanged in the next cycle.
- R4: With halt_low = 0, a halt request present at an arbitration point halts the port from the next cycle, whatever the masters request.
- R5: With halt_low = 1, the port halts only at an arbitration point where no master requests. If any master requests there, normal arbitration happens instead.
- R6: Once halted, the port stays halted while halt_req is high, regardless of requests, strobes, hold bits and halt_low.
- R7: While halted, halted = 1, the grant is all zero, and the slave address, control, write data and transfer type are all zero.
- R8: In the cycle after halt_req is seen low in the halted state, the port is no longer halted. The owner becomes the lowest-index requester, or stays the last owner if nobody requests.
- R9: A halt request that drops before reaching an arbitration point has no effect. The current owner keeps the port unless normal arbitration moves it.
- R10: When the owner is not requesting, the slave transfer type is IDLE (2'b00). Otherwise the slave outputs equal the owner's address, control, write data and transfer type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | N | Per-master access request |
| m_hold | input | N | Per-master locked / fixed-burst in progress (blocks arbitration) |
| m_addr | input | N*AW | Per-master address, master i in bits [i*AW +: AW] |
| m_ctrl | input | N*CW | Per-master control attributes |
| m_wdata | input | N*DW | Per-master write data |
| m_trans | input | N*2 | Per-master transfer type, 2'b00 = IDLE |
| xfer_end | input | 1 | Transfer-boundary strobe |
| halt_req | input | 1 | Halt request |
| halt_low | input | 1 | Halt priority: 0 = above all masters, 1 = only when idle |
| grant | output | N | One-hot owner, all zero when halted |
| halted | output | 1 | Port is in halt |
| s_addr | output | AW | Slave-side address |
| s_ctrl | output | CW | Slave-side control |
| s_wdata | output | DW | Slave-side write data |
| s_trans | output | 2 | Slave-side transfer type |

## Verification
Arbitration among the masters and the halt decision are made at the same arbitration point. This matters most when a halt request and master requests are present in the same strobe cycle, and the result there depends on halt_low. The bench provokes this collision with directed cycles and with random stimulus that holds halt_req and toggles halt_low over long runs. A halt request is also raised and then dropped just before a strobe, which tests cancellation. A reference model in the bench, written from the requirements, predicts the grant, the halted flag and the slave outputs each cycle. Each check is tagged with the transition the model took.

// File: rtl/slvarb_pkg.sv
package slvarb_pkg;
    typedef enum logic {
        ST_OWN  = 1'b0,
        ST_HALT = 1'b1
    } arb_state_e;

    localparam int TRANS_W = 2;
    localparam logic [TRANS_W-1:0] TRANS_IDLE = 2'b00;
endpackage

// File: rtl/slvarb_prio.sv
module slvarb_prio #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any_req,
    output logic [IW-1:0] win_idx
);
    always_comb begin
        any_req = |req;
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) win_idx = IW'(i);
        end
    end
endmodule

// File: rtl/slvarb_fsm.sv
module slvarb_fsm
    import slvarb_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  m_hold,
    input  logic          xfer_end,
    input  logic          halt_req,
    input  logic          halt_low,
    input  logic          any_req,
    input  logic [IW-1:0] win_idx,
    output logic [N-1:0]  grant,
    output logic          halted
);
    arb_state_e    state, nxt_state;
    logic [IW-1:0] owner, nxt_owner;
    logic          arb_pt;

    assign arb_pt = xfer_end && !m_hold[owner];

    always_comb begin
        nxt_state = state;
        nxt_owner = owner;
        unique case (state)
            ST_OWN: begin
                if (arb_pt) begin
                    if (halt_req && (!halt_low || !any_req)) begin
                        nxt_state = ST_HALT;
                    end else if (any_req) begin
                        nxt_owner = win_idx;
                    end
                end
            end
            ST_HALT: begin
                if (!halt_req) begin
                    nxt_state = ST_OWN;
                    if (any_req) nxt_owner = win_idx;
                end
            end
            default: nxt_state = ST_OWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OWN;
            owner <= '0;
        end else begin
            state <= nxt_state;
            owner <= nxt_owner;
        end
    end

    always_comb begin
        grant  = '0;
        halted = 1'b0;
        unique case (state)
            ST_OWN:  grant[owner] = 1'b1;
            ST_HALT: halted = 1'b1;
            default: halted = 1'b0;
        endcase
    end
endmodule

// File: rtl/slvarb_mux.sv
module slvarb_mux
    import slvarb_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 32,
    parameter int CW = 8,
    parameter int DW = 32
) (
    input  logic [N-1:0]         grant,
    input  logic [N-1:0]         m_req,
    input  logic [N*AW-1:0]      m_addr,
    input  logic [N*CW-1:0]      m_ctrl,
    input  logic [N*DW-1:0]      m_wdata,
    input  logic [N*TRANS_W-1:0] m_trans,
    output logic [AW-1:0]        s_addr,
    output logic [CW-1:0]        s_ctrl,
    output logic [DW-1:0]        s_wdata,
    output logic [TRANS_W-1:0]   s_trans
);
    logic [AW-1:0]      a_m [N];
    logic [CW-1:0]      c_m [N];
    logic [DW-1:0]      d_m [N];
    logic [TRANS_W-1:0] t_m [N];

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign a_m[i] = m_addr [i*AW +: AW] & {AW{grant[i]}};
        assign c_m[i] = m_ctrl [i*CW +: CW] & {CW{grant[i]}};
        assign d_m[i] = m_wdata[i*DW +: DW] & {DW{grant[i]}};
        assign t_m[i] = m_trans[i*TRANS_W +: TRANS_W] & {TRANS_W{grant[i] & m_req[i]}};
    end

    always_comb begin
        s_addr  = '0;
        s_ctrl  = '0;
        s_wdata = '0;
        s_trans = TRANS_IDLE;
        for (int i = 0; i < N; i++) begin
            s_addr  = s_addr  | a_m[i];
            s_ctrl  = s_ctrl  | c_m[i];
            s_wdata = s_wdata | d_m[i];
            s_trans = s_trans | t_m[i];
        end
    end
endmodule

// File: rtl/slvport_arbiter.sv
module slvport_arbiter
    import slvarb_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 32,
    parameter int CW = 8,
    parameter int DW = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         m_req,
    input  logic [N-1:0]         m_hold,
    input  logic [N*AW-1:0]      m_addr,
    input  logic [N*CW-1:0]      m_ctrl,
    input  logic [N*DW-1:0]      m_wdata,
    input  logic [N*TRANS_W-1:0] m_trans,
    input  logic                 xfer_end,
    input  logic                 halt_req,
    input  logic                 halt_low,
    output logic [N-1:0]         grant,
    output logic                 halted,
    output logic [AW-1:0]        s_addr,
    output logic [CW-1:0]        s_ctrl,
    output logic [DW-1:0]        s_wdata,
    output logic [TRANS_W-1:0]   s_trans
);
    logic          any_req;
    logic [IW-1:0] win_idx;

    slvarb_prio #(.N(N)) u_prio (
        .req     (m_req),
        .any_req (any_req),
        .win_idx (win_idx)
    );

    slvarb_fsm #(.N(N)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_hold   (m_hold),
        .xfer_end (xfer_end),
        .halt_req (halt_req),
        .halt_low (halt_low),
        .any_req  (any_req),
        .win_idx  (win_idx),
        .grant    (grant),
        .halted   (halted)
    );

    slvarb_mux #(.N(N), .AW(AW), .CW(CW), .DW(DW)) u_mux (
        .grant   (grant),
        .m_req   (m_req),
        .m_addr  (m_addr),
        .m_ctrl  (m_ctrl),
        .m_wdata (m_wdata),
        .m_trans (m_trans),
        .s_addr  (s_addr),
        .s_ctrl  (s_ctrl),
        .s_wdata (s_wdata),
        .s_trans (s_trans)
    );
endmodule

// File: rtl/slvarb_checker.sv
module slvarb_checker #(
    parameter int N  = 4,
    parameter int AW = 32,
    parameter int CW = 8,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  m_req,
    input logic [N-1:0]  m_hold,
    input logic          xfer_end,
    input logic          halt_req,
    input logic          halt_low,
    input logic [N-1:0]  grant,
    input logic          halted,
    input logic [AW-1:0] s_addr,
    input logic [CW-1:0] s_ctrl,
    input logic [DW-1:0] s_wdata,
    input logic [1:0]    s_trans
);
    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |-> $countones(grant) == 1);

    a_r3_no_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !xfer_end) |=> $stable(grant));

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && (m_hold & grant) != '0) |=> $stable(grant));

    a_r4_high_prio_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !halt_low && halt_req && xfer_end && (m_hold & grant) == '0) |=> halted);

    a_r5_low_prio_yield: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && halt_low && m_req != '0) |=> !halted);

    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && halt_req) |=> halted);

    a_r7_halt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (grant == '0 && s_addr == '0 && s_ctrl == '0 &&
                    s_wdata == '0 && s_trans == 2'b00));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !halt_req) |=> !halted);

    a_r10_park_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && (m_req & grant) == '0) |-> s_trans == 2'b00);
endmodule

bind slvport_arbiter slvarb_checker #(.N(N), .AW(AW), .CW(CW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_req    (m_req),
    .m_hold   (m_hold),
    .xfer_end (xfer_end),
    .halt_req (halt_req),
    .halt_low (halt_low),
    .grant    (grant),
    .halted   (halted),
    .s_addr   (s_addr),
    .s_ctrl   (s_ctrl),
    .s_wdata  (s_wdata),
    .s_trans  (s_trans)
);

// File: tb/slvport_arbiter_tb.sv
module slvport_arbiter_tb;
    localparam int N  = 4;
    localparam int AW = 32;
    localparam int CW = 8;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    m_req = '0, m_hold = '0;
    logic [N*AW-1:0] m_addr = '0;
    logic [N*CW-1:0] m_ctrl = '0;
    logic [N*DW-1:0] m_wdata = '0;
    logic [N*2-1:0]  m_trans = '0;
    logic            xfer_end = 1'b0, halt_req = 1'b0, halt_low = 1'b0;
    logic [N-1:0]    grant;
    logic            halted;
    logic [AW-1:0]   s_addr;
    logic [CW-1:0]   s_ctrl;
    logic [DW-1:0]   s_wdata;
    logic [1:0]      s_trans;

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    bit    e_halt  = 1'b0;
    int    e_own   = 0;
    bit    e_prevh = 1'b0;
    string e_tag   = "R1";

    always #5 clk = ~clk;

    slvport_arbiter #(.N(N), .AW(AW), .CW(CW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_hold(m_hold),
        .m_addr(m_addr), .m_ctrl(m_ctrl), .m_wdata(m_wdata), .m_trans(m_trans),
        .xfer_end(xfer_end), .halt_req(halt_req), .halt_low(halt_low),
        .grant(grant), .halted(halted), .s_addr(s_addr), .s_ctrl(s_ctrl),
        .s_wdata(s_wdata), .s_trans(s_trans)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] r);
        for (int i = N - 1; i >= 0; i--) if (r[i]) lowest = i;
        if (r == '0) lowest = -1;
    endfunction

    function automatic logic [N-1:0] exp_grant();
        logic [N-1:0] g = '0;
        if (!e_halt) g[e_own] = 1'b1;
        return g;
    endfunction

    task automatic rand_fields();
        for (int i = 0; i < N; i++) begin
            m_addr [i*AW +: AW] = $urandom;
            m_ctrl [i*CW +: CW] = CW'($urandom);
            m_wdata[i*DW +: DW] = $urandom;
            m_trans[i*2 +: 2]   = 2'($urandom);
        end
    endtask

    task automatic check_outputs();
        logic [AW-1:0] ea;
        logic [CW-1:0] ec;
        logic [DW-1:0] ed;
        logic [1:0]    et;
        string         ttag;
        ea = e_halt ? '0 : m_addr [e_own*AW +: AW];
        ec = e_halt ? '0 : m_ctrl [e_own*CW +: CW];
        ed = e_halt ? '0 : m_wdata[e_own*DW +: DW];
        et = (e_halt || !m_req[e_own]) ? 2'b00 : m_trans[e_own*2 +: 2];
        ttag = e_halt ? "R7" : (!m_req[e_own] ? "R10" : e_tag);
        chk(grant == exp_grant(), e_tag, "grant", 64'(grant), 64'(exp_grant()));
        chk(halted == e_halt, e_halt ? "R7" : e_tag, "halted", 64'(halted), 64'(e_halt));
        chk(s_trans == et, ttag, "s_trans", 64'(s_trans), 64'(et));
        chk(s_addr == ea && s_ctrl == ec && s_wdata == ed, e_halt ? "R7" : "R10",
            "s_addr", 64'(s_addr), 64'(ea));
    endtask

    task automatic model_update();
        bit arb;
        int w;
        arb = xfer_end && !m_hold[e_own];
        w = lowest(m_req);
        if (e_halt) begin
            if (halt_req) e_tag = "R6";
            else begin
                e_tag = "R8";
                e_halt = 1'b0;
                if (w >= 0) e_own = w;
            end
        end else if (!arb) begin
            e_tag = (e_prevh && !halt_req) ? "R9" : "R3";
        end else if (halt_req && (!halt_low || m_req == '0)) begin
            e_tag = halt_low ? "R5" : "R4";
            e_halt = 1'b1;
        end else begin
            if (halt_req) e_tag = "R5";
            else if (e_prevh) e_tag = "R9";
            else e_tag = "R2";
            if (w >= 0) e_own = w;
        end
        e_prevh = halt_req;
    endtask

    // drive at negedge, check, then advance model across posedge
    task automatic step(input logic [N-1:0] rq, input logic [N-1:0] hd,
                        input bit xe, input bit hr, input bit lo);
        @(negedge clk);
        m_req = rq; m_hold = hd; xfer_end = xe; halt_req = hr; halt_low = lo;
        rand_fields();
        #1;
        check_outputs();
        @(posedge clk);
        model_update();
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        chk(grant == 4'b0001, "R1", "grant", 64'(grant), 64'h1);
        chk(halted == 1'b0, "R1", "halted", 64'(halted), 64'h0);
        chk(s_trans == 2'b00, "R1", "s_trans", 64'(s_trans), 64'h0);

        // R2: lowest index requester wins
        step(4'b1010, 4'b0000, 1, 0, 0);
        step(4'b1010, 4'b0000, 0, 0, 0);
        // R3: owner holds, strobe ignored
        step(4'b0011, 4'b0010, 1, 0, 0);
        step(4'b0011, 4'b0000, 1, 0, 0);
        // R9: halt raised then dropped before an arbitration point
        step(4'b0001, 4'b0000, 0, 1, 0);
        step(4'b0001, 4'b0000, 1, 0, 0);
        // R4: high-priority halt preempts requesting masters
        step(4'b1111, 4'b0000, 1, 1, 0);
        // R6/R7: held while request stays, priority bit flipped
        step(4'b1111, 4'b1111, 1, 1, 1);
        step(4'b0110, 4'b0000, 1, 1, 0);
        // R8: release, lowest requester takes the port
        step(4'b0100, 4'b0000, 0, 0, 0);
        step(4'b0100, 4'b0000, 0, 0, 1);
        // R5: low-priority halt yields to requests, takes idle port
        step(4'b0100, 4'b0000, 1, 1, 1);
        step(4'b0000, 4'b0000, 1, 1, 1);
        step(4'b0000, 4'b0000, 1, 1, 1);
        // R8/R10: release with nobody requesting, parked on last owner
        step(4'b0000, 4'b0000, 0, 0, 1);
        step(4'b0000, 4'b0000, 1, 0, 0);
        step(4'b0000, 4'b0000, 0, 0, 0);

        // constrained random
        begin
            bit hr = 1'b0;
            bit lo = 1'b0;
            for (int c = 0; c < 3000; c++) begin
                logic [N-1:0] rq, hd;
                rq = N'($urandom & $urandom);
                hd = ($urandom % 6 == 0) ? N'($urandom) : '0;
                if ($urandom % 12 == 0) hr = ~hr;
                if ($urandom % 50 == 0) lo = ~lo;
                step(rq, hd, 1'($urandom), hr, lo);
            end
        end
        @(negedge clk);
        #1;
        check_outputs();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule